// File: doc/BRIEF.md
# Frame-Rate Family Detector

The block decides whether a recovered serial-video clock runs at an integer frame-rate frequency (for example 148.5 MHz or 74.25 MHz) or at the 1/1.001 variant of it (148.35 MHz or 74.175 MHz). It counts recovered-clock cycles over a fixed window of 2^WIN_LOG2 cycles of a local reference clock. It compares the count against an expected value and reports the rate family on a single registered flag: 0 means integer rate and 1 means 1/1.001 rate. A one-cycle valid strobe marks each finished measurement.

Two static inputs set the comparison. The first, `ref_is_frac_i`, states the reference clock's own family. It is 0 for a 297 MHz, 148.5 MHz or 74.25 MHz reference and 1 for a 296.7 MHz, 148.35 MHz or 74.175 MHz reference. The second, `ratio_sel_i`, states how much slower the recovered clock nominally runs than the reference (1:1, 1:2 or 1:4).

The window boundary and the count cross between the clock domains through toggle handshakes. A two-window agreement filter keeps the flag steady. A count far from every plausible value raises an out-of-range indication instead of moving the flag. The decision is only correct when `ref_is_frac_i` matches the real reference clock.

Top module: `rate_family_detect`

## Requirements
- R1: The expected count is E = 2^WIN_LOG2 / r, where ratio_sel_i = 0, 1, 2 gives r = 1, 2, 4 and the code 3 behaves as 2. With the default WIN_LOG2 = 16, a 1:1 ratio gives E = 65536. A recovered clock at the nominal ratio is classified in range for its own ratio setting. The same clock under a smaller ratio code is out of range.
- R2: The rule when ref_is_frac_i = 0 uses T = E/2048 and F = E/64 + E/256. A count in [E-T, E+F] gives class 0 (integer rate). A count in [E-F, E-T) gives class 1 (1/1.001 rate).
- R3: The rule when ref_is_frac_i = 1 is different. A count in [E-F, E+T] gives class 1. A count in (E+T, E+F] gives class 0. A recovered clock equal to an integer-rate reference is therefore reported as 1 when the input wrongly states 1.
- R4: A count below E-F or above E+F drives out_of_range_o to 1 for that measurement. frac_rate_o keeps its value, and the agreement filter restarts. out_of_range_o changes only together with valid_o.
- R5: frac_rate_o changes only on a valid_o cycle. It takes a class only when two consecutive in-range windows produce that same class.
- R6: valid_o is a one-cycle pulse, one per window of 2^WIN_LOG2 reference cycles. The first window after reset is discarded, so the first pulse comes about two windows after reset is released.
- R7: While rst_i (synchronous, active high, reference domain) is asserted, and on the cycle after it, frac_rate_o, valid_o and out_of_range_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk_i | input | 1 | Local reference clock that times the window |
| rst_i | input | 1 | Synchronous active-high reset, reference domain |
| rec_clk_i | input | 1 | Recovered clock being classified |
| ref_is_frac_i | input | 1 | Static: 1 when the reference clock is a 1/1.001-rate frequency |
| ratio_sel_i | input | 2 | Static: nominal recovered:reference ratio, 0 = 1:1, 1 = 1:2, 2 = 1:4 |
| frac_rate_o | output | 1 | 0 = integer rate, 1 = 1/1.001 rate |
| valid_o | output | 1 | One-cycle pulse after each measurement |
| out_of_range_o | output | 1 | Last count was far from every expected value |

## Verification
The main function is tried with four kinds of recovered clock: exactly the reference rate, 1000 ppm slower, 1000 ppm faster, and 5% slower. Each is applied with both settings of the reference-family input. This separates the two halves of the decision rule and shows that the strap inverts the result for a matching clock. Clocks at half and quarter rate under their own and a wrong ratio code show whether the expected count is scaled. Directed sequences switch the clock between windows to show the one-window lag of the filter and the flag being held through out-of-range windows.

// File: rtl/rfd_pkg.sv
package rfd_pkg;

  // Result of classifying one measurement window.
  typedef struct packed {
    logic cls;  // 1 = 1/1.001 family
    logic oor;  // count outside every plausible band
  } verdict_t;

  localparam int TOL_SHIFT   = 11;  // ~488 ppm band
  localparam int FAR_SHIFT_A = 6;   // far band ~1.95 %
  localparam int FAR_SHIFT_B = 8;

endpackage

// File: rtl/rfd_rec_count.sv
// Recovered-clock domain: counts cycles between window toggles and hands
// the finished count back with an acknowledge toggle.
module rfd_rec_count #(
  parameter int CNT_W = 20
) (
  input  logic             rec_clk_i,
  input  logic             rst_i,       // reference-domain reset, re-synchronised here
  input  logic             win_tog_i,
  output logic [CNT_W-1:0] hold_o,
  output logic             ack_tog_o
);

  logic             rr1, rr2;
  logic             ws1, ws2, ws3;
  logic [CNT_W-1:0] cnt_q;
  logic             edge_w;

  always_ff @(posedge rec_clk_i) begin
    rr1 <= rst_i;
    rr2 <= rr1;
  end

  assign edge_w = ws2 ^ ws3;

  always_ff @(posedge rec_clk_i) begin
    if (rr2) begin
      ws1       <= 1'b0;
      ws2       <= 1'b0;
      ws3       <= 1'b0;
      cnt_q     <= '0;
      hold_o    <= '0;
      ack_tog_o <= 1'b0;
    end else begin
      ws1 <= win_tog_i;
      ws2 <= ws1;
      ws3 <= ws2;
      if (edge_w) begin
        hold_o    <= cnt_q;
        cnt_q     <= CNT_W'(1);
        ack_tog_o <= ~ack_tog_o;
      end else if (cnt_q != {CNT_W{1'b1}}) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/rfd_ref_ctrl.sv
// Reference domain: window timer, window toggle, and capture of the count
// returned by the recovered-clock side.
module rfd_ref_ctrl #(
  parameter int WIN_LOG2 = 16,
  parameter int CNT_W    = 20
) (
  input  logic             ref_clk_i,
  input  logic             rst_i,
  input  logic             ack_tog_i,
  input  logic [CNT_W-1:0] hold_i,
  output logic             win_tog_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cnt_vld_o
);

  logic [WIN_LOG2-1:0] tmr_q;
  logic                wrapped_q;   // first toggle has been issued
  logic                skipped_q;   // first, partial window already dropped
  logic                as1, as2, as3;
  logic                ack_edge;

  assign ack_edge = as2 ^ as3;

  always_ff @(posedge ref_clk_i) begin
    if (rst_i) begin
      tmr_q     <= '0;
      win_tog_o <= 1'b0;
      wrapped_q <= 1'b0;
    end else begin
      tmr_q <= tmr_q + WIN_LOG2'(1);
      if (&tmr_q) begin
        win_tog_o <= ~win_tog_o;
        wrapped_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge ref_clk_i) begin
    if (rst_i) begin
      as1       <= 1'b0;
      as2       <= 1'b0;
      as3       <= 1'b0;
      skipped_q <= 1'b0;
      cnt_o     <= '0;
      cnt_vld_o <= 1'b0;
    end else begin
      as1       <= ack_tog_i;
      as2       <= as1;
      as3       <= as2;
      cnt_vld_o <= 1'b0;
      if (ack_edge && wrapped_q) begin
        if (!skipped_q) begin
          skipped_q <= 1'b1;
        end else begin
          cnt_o     <= hold_i;
          cnt_vld_o <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rfd_classify.sv
// Turns one window count into a family class or an out-of-range verdict.
module rfd_classify
  import rfd_pkg::*;
#(
  parameter int WIN_LOG2 = 16,
  parameter int CNT_W    = 20
) (
  input  logic             ref_clk_i,
  input  logic             rst_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_vld_i,
  input  logic             ref_is_frac_i,
  input  logic [1:0]       ratio_sel_i,
  output verdict_t         verdict_o,
  output logic             verdict_vld_o
);

  localparam logic [CNT_W-1:0] WIN_CNT = CNT_W'(1) << WIN_LOG2;

  logic [1:0]       shift_w;
  logic [CNT_W-1:0] exp_w, tol_w, far_w;
  logic [CNT_W-1:0] lo_far, hi_far, lo_tol, hi_tol;
  verdict_t         next_w;

  always_comb begin
    shift_w = (ratio_sel_i == 2'd3) ? 2'd2 : ratio_sel_i;
    exp_w   = WIN_CNT >> shift_w;
    tol_w   = exp_w >> TOL_SHIFT;
    far_w   = (exp_w >> FAR_SHIFT_A) + (exp_w >> FAR_SHIFT_B);
    lo_far  = exp_w - far_w;
    hi_far  = exp_w + far_w;
    lo_tol  = exp_w - tol_w;
    hi_tol  = exp_w + tol_w;
    next_w.oor = (cnt_i < lo_far) || (cnt_i > hi_far);
    next_w.cls = ref_is_frac_i ? (cnt_i <= hi_tol) : (cnt_i < lo_tol);
  end

  always_ff @(posedge ref_clk_i) begin
    if (rst_i) begin
      verdict_o     <= '0;
      verdict_vld_o <= 1'b0;
    end else begin
      verdict_vld_o <= cnt_vld_i;
      if (cnt_vld_i) verdict_o <= next_w;
    end
  end

endmodule

// File: rtl/rfd_hyst.sv
// Two-window agreement filter and output registers.
module rfd_hyst
  import rfd_pkg::*;
(
  input  logic     ref_clk_i,
  input  logic     rst_i,
  input  verdict_t verdict_i,
  input  logic     verdict_vld_i,
  output logic     frac_rate_o,
  output logic     valid_o,
  output logic     out_of_range_o
);

  logic prev_cls_q;
  logic have_prev_q;

  always_ff @(posedge ref_clk_i) begin
    if (rst_i) begin
      frac_rate_o    <= 1'b0;
      valid_o        <= 1'b0;
      out_of_range_o <= 1'b0;
      prev_cls_q     <= 1'b0;
      have_prev_q    <= 1'b0;
    end else begin
      valid_o <= verdict_vld_i;
      if (verdict_vld_i) begin
        out_of_range_o <= verdict_i.oor;
        if (verdict_i.oor) begin
          have_prev_q <= 1'b0;
        end else begin
          if (have_prev_q && (prev_cls_q == verdict_i.cls))
            frac_rate_o <= verdict_i.cls;
          prev_cls_q  <= verdict_i.cls;
          have_prev_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rate_family_detect.sv
module rate_family_detect
  import rfd_pkg::*;
#(
  parameter int WIN_LOG2 = 16,
  parameter int CNT_W    = 20
) (
  input  logic       ref_clk_i,
  input  logic       rst_i,
  input  logic       rec_clk_i,
  input  logic       ref_is_frac_i,
  input  logic [1:0] ratio_sel_i,
  output logic       frac_rate_o,
  output logic       valid_o,
  output logic       out_of_range_o
);

  logic             win_tog;
  logic             ack_tog;
  logic [CNT_W-1:0] hold_cnt;
  logic [CNT_W-1:0] cap_cnt;
  logic             cap_vld;
  verdict_t         verdict;
  logic             verdict_vld;

  rfd_ref_ctrl #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) ref_ctrl_i (
    .ref_clk_i (ref_clk_i),
    .rst_i     (rst_i),
    .ack_tog_i (ack_tog),
    .hold_i    (hold_cnt),
    .win_tog_o (win_tog),
    .cnt_o     (cap_cnt),
    .cnt_vld_o (cap_vld)
  );

  rfd_rec_count #(.CNT_W(CNT_W)) rec_count_i (
    .rec_clk_i (rec_clk_i),
    .rst_i     (rst_i),
    .win_tog_i (win_tog),
    .hold_o    (hold_cnt),
    .ack_tog_o (ack_tog)
  );

  rfd_classify #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) classify_i (
    .ref_clk_i     (ref_clk_i),
    .rst_i         (rst_i),
    .cnt_i         (cap_cnt),
    .cnt_vld_i     (cap_vld),
    .ref_is_frac_i (ref_is_frac_i),
    .ratio_sel_i   (ratio_sel_i),
    .verdict_o     (verdict),
    .verdict_vld_o (verdict_vld)
  );

  rfd_hyst hyst_i (
    .ref_clk_i      (ref_clk_i),
    .rst_i          (rst_i),
    .verdict_i      (verdict),
    .verdict_vld_i  (verdict_vld),
    .frac_rate_o    (frac_rate_o),
    .valid_o        (valid_o),
    .out_of_range_o (out_of_range_o)
  );

endmodule

// File: rtl/rate_family_detect_chk.sv
module rate_family_detect_chk (
  input logic ref_clk_i,
  input logic rst_i,
  input logic frac_rate_o,
  input logic valid_o,
  input logic out_of_range_o
);

  AST_VALID_ONE_CYCLE: assert property (@(posedge ref_clk_i) disable iff (rst_i)
    valid_o |=> !valid_o);  // R6

  AST_FLAG_STEPS_ON_VALID: assert property (@(posedge ref_clk_i) disable iff (rst_i)
    (frac_rate_o != $past(frac_rate_o)) |-> (valid_o && !out_of_range_o));  // R5

  AST_OOR_KEEPS_FLAG: assert property (@(posedge ref_clk_i) disable iff (rst_i)
    (valid_o && out_of_range_o) |-> (frac_rate_o == $past(frac_rate_o)));  // R4

  AST_OOR_STEPS_ON_VALID: assert property (@(posedge ref_clk_i) disable iff (rst_i)
    (out_of_range_o != $past(out_of_range_o)) |-> valid_o);  // R4

  AST_RESET_CLEARS: assert property (@(posedge ref_clk_i)
    rst_i |=> (!valid_o && !frac_rate_o && !out_of_range_o));  // R7

endmodule

bind rate_family_detect rate_family_detect_chk chk_i (
  .ref_clk_i      (ref_clk_i),
  .rst_i          (rst_i),
  .frac_rate_o    (frac_rate_o),
  .valid_o        (valid_o),
  .out_of_range_o (out_of_range_o)
);

// File: tb/rate_family_detect_tb_top.sv
module rate_family_detect_tb_top;

  localparam int WIN_LOG2 = 12;
  localparam int CNT_W    = 16;
  localparam int WIN      = 1 << WIN_LOG2;

  typedef struct packed {
    logic       fam;
    logic [1:0] sel;
    int         hi;    // recovered clock high time, ps
    int         lo;    // recovered clock low time, ps
    logic       flag;
    logic       oor;
  } vec_t;

  // Reference period 5000 ps. 5005 ps = 1000 ppm slow, 4995 ps = 1000 ppm fast.
  localparam vec_t VEC [8] = '{
    '{1'b0, 2'd0, 2500,  2500,  1'b0, 1'b0},  // R2 integer rate, strap 0
    '{1'b0, 2'd0, 2502,  2503,  1'b1, 1'b0},  // R2 1/1.001 rate, strap 0
    '{1'b1, 2'd0, 2502,  2503,  1'b1, 1'b0},  // R3 matches slow reference
    '{1'b1, 2'd0, 2497,  2498,  1'b0, 1'b0},  // R3 integer rate vs slow reference
    '{1'b1, 2'd0, 2500,  2500,  1'b1, 1'b0},  // R3 wrong strap inverts
    '{1'b0, 2'd1, 5000,  5000,  1'b0, 1'b0},  // R1 half rate, 1:2 code
    '{1'b0, 2'd2, 10000, 10000, 1'b0, 1'b0},  // R1 quarter rate, 1:4 code
    '{1'b0, 2'd0, 5000,  5000,  1'b0, 1'b1}   // R1 half rate, wrong 1:1 code
  };

  logic       ref_clk = 1'b0;
  logic       rec_clk = 1'b0;
  logic       rst     = 1'b1;
  logic       fam     = 1'b0;
  logic [1:0] sel     = 2'd0;
  int         rec_hi  = 2500;
  int         rec_lo  = 2500;
  logic       frac_rate, valid, oor;

  int checks   = 0;
  int failures = 0;

  rate_family_detect #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) dut_i (
    .ref_clk_i      (ref_clk),
    .rst_i          (rst),
    .rec_clk_i      (rec_clk),
    .ref_is_frac_i  (fam),
    .ratio_sel_i    (sel),
    .frac_rate_o    (frac_rate),
    .valid_o        (valid),
    .out_of_range_o (oor)
  );

  always #2500 ref_clk = ~ref_clk;

  initial begin
    forever begin
      rec_clk = 1'b1;
      #(rec_hi);
      rec_clk = 1'b0;
      #(rec_lo);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_valids(input int n);
    repeat (n) begin
      @(negedge ref_clk);
      while (!valid) @(negedge ref_clk);
    end
  endtask

  task automatic set_rec(input int hi, input int lo);
    rec_hi = hi;
    rec_lo = lo;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (195000) @(posedge ref_clk);
    failures++;
    $display("FAIL R6 watchdog actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    int gap;
    repeat (4) @(negedge ref_clk);
    chk("R7 reset flag", frac_rate, 0);
    chk("R7 reset valid", valid, 0);
    chk("R7 reset oor", oor, 0);
    rst = 1'b0;

    // Vector table: each entry settles for one mixed and two clean windows.
    for (int i = 0; i < 8; i++) begin
      fam = VEC[i].fam;
      sel = VEC[i].sel;
      set_rec(VEC[i].hi, VEC[i].lo);
      wait_valids(3);
      chk($sformatf("R1/R2/R3 vector %0d flag", i), frac_rate, VEC[i].flag);
      chk($sformatf("R1/R4 vector %0d oor", i), oor, VEC[i].oor);
    end

    // R4: flag held through out-of-range windows.
    fam = 1'b0;
    sel = 2'd0;
    set_rec(2502, 2503);
    wait_valids(3);
    chk("R2 slow clock sets flag", frac_rate, 1);
    set_rec(2625, 2625);
    wait_valids(1);
    chk("R4 far count raises oor", oor, 1);
    chk("R4 flag held on oor", frac_rate, 1);
    @(negedge ref_clk);
    chk("R6 valid lasts one cycle", valid, 0);
    wait_valids(1);
    chk("R4 flag still held", frac_rate, 1);
    set_rec(2502, 2503);
    wait_valids(1);
    chk("R4 oor clears in range", oor, 0);

    // R5: one disagreeing window does not move the flag, two do.
    set_rec(2500, 2500);
    wait_valids(1);
    chk("R5 single window ignored", frac_rate, 1);
    wait_valids(1);
    chk("R5 two windows agree", frac_rate, 0);

    // R6: spacing between pulses equals one window.
    gap = 0;
    @(negedge ref_clk);
    while (!valid) begin
      gap++;
      @(negedge ref_clk);
    end
    chk("R6 window length", (gap >= WIN - 2 && gap <= WIN) ? 1 : 0, 1);

    // R7 / R6: reset mid-run, then the first window is dropped.
    rst = 1'b1;
    @(negedge ref_clk);
    @(negedge ref_clk);
    chk("R7 reset mid-run flag", frac_rate, 0);
    chk("R7 reset mid-run valid", valid, 0);
    chk("R7 reset mid-run oor", oor, 0);
    rst = 1'b0;
    gap = 0;
    @(negedge ref_clk);
    while (!valid) begin
      gap++;
      @(negedge ref_clk);
    end
    chk("R6 first window discarded", (gap >= 2 * WIN - 4 && gap <= 2 * WIN + 24) ? 1 : 0, 1);

    summary();
    $finish;
  end

endmodule